// File: doc/BRIEF.md
# Multi-Channel Digital Silence Detector

This block watches six channels of decoded audio and tells the rest of the system when the programme material has gone silent. The caller presents one sample frame per `frameValid` strobe. The frame carries six signed samples packed side by side. The block counts consecutive frames in which every participating channel holds an exact zero. Once that run reaches a threshold, the active-low flag `silenceN` falls. The default threshold is 9600 frames, which is 200 ms at a 48 kHz sample rate.

Which channels take part is set in one of two ways. In control-port mode a per-channel participation mask chooses them. In static mode all six channels take part and the mask is ignored. A digital mute request pulls the flag low at once and independently of the count. The external logic can use the flag to mute downstream stages or to pause a recorder.

Top module: `silence_watch`

## Requirements
- R1: After reset, with `muteReq` low, `silenceN` is 1 and the silence run count is zero.
- R2: `silenceN` falls on the clock edge that accepts the THRESHOLD-th consecutive silent valid frame. It is still 1 after THRESHOLD-1 such frames. A frame is silent when every participating channel carries zero.
- R3: A cycle with `frameValid` low neither advances nor clears the run. Inputs other than `frameValid` are ignored in that cycle.
- R4: A valid frame in which any participating channel is non-zero clears the run. `silenceN` returns to 1 on the edge that accepts that frame.
- R5: The run saturates at THRESHOLD. Further silent frames keep `silenceN` low, and the count does not wrap.
- R6: `muteReq` high drives `silenceN` low in the same cycle, whatever the count. Mute does not alter the count, so after mute is released the flag follows the run again.
- R7: In control-port mode (`staticMode` = 0), channel i takes part only when `partMask[i]` is 1. A non-zero sample on a channel whose mask bit is 0 has no effect. Channel i occupies `samples[i*SAMPLE_W +: SAMPLE_W]`.
- R8: In static mode (`staticMode` = 1), all channels take part regardless of `partMask`.
- R9: In control-port mode with `partMask` all zero, every valid frame clears the run, and `silenceN` stays 1 unless `muteReq` is high.
- R10: A sample counts as zero only when all SAMPLE_W bits are 0. A sample with only its LSB set, or only its sign bit set, is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameValid | input | 1 | One sample frame is present this cycle |
| samples | input | NUM_CH*SAMPLE_W | Packed samples; channel i at bits i*SAMPLE_W upward |
| partMask | input | NUM_CH | Per-channel participation enable (control-port mode) |
| staticMode | input | 1 | 1 = all channels take part, mask ignored |
| muteReq | input | 1 | Digital mute active (control port or static mute pin) |
| silenceN | output | 1 | Active-low silence flag |

## Verification
The hardest situation to reach from the ports is the saturated run meeting a single offending sample. That sample may sit on a masked or on a participating channel, and the outcome depends on both the mask and the static-mode select. The bench uses a small threshold, which keeps saturation only a few frames away. It then sweeps all 64 masks in both modes. After each fill to saturation, it injects a non-zero sample on each channel in turn and compares the result with an arithmetic model of the run length.

// File: rtl/silence_pkg.sv
package silence_pkg;
  // Strobes from control to the run counter
  typedef struct packed {
    logic clr;   // restart the silent run
    logic adv;   // one more silent frame
  } run_cmd_t;
endpackage

// File: rtl/silence_ctrl.sv
module silence_ctrl
  import silence_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [NUM_CH-1:0] chanZero,
  input  logic [NUM_CH-1:0] partMask,
  input  logic              staticMode,
  output run_cmd_t          cmd
);
  logic [NUM_CH-1:0] effMask;
  logic              anyPart;
  logic              offender;

  always_comb begin
    effMask  = staticMode ? {NUM_CH{1'b1}} : partMask;
    anyPart  = |effMask;
    offender = |(effMask & ~chanZero);
    cmd.clr  = frameValid && (offender || !anyPart);
    cmd.adv  = frameValid && anyPart && !offender;
  end

  // R3: no frame, no strobe
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |-> (cmd.clr == 1'b0 && cmd.adv == 1'b0));
  // R8: static mode, any non-zero channel restarts the run
  a_r8_static_all: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && staticMode && !(&chanZero)) |-> cmd.clr);
  // R7: masked-off channels cannot break a run
  a_r7_masked_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !staticMode && (|partMask) && ((chanZero | ~partMask) == {NUM_CH{1'b1}}))
      |-> cmd.adv);
  // R9: empty mask never advances
  a_r9_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !staticMode && partMask == '0) |-> cmd.clr);
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmd.clr, cmd.adv}));
endmodule

// File: rtl/silence_dp.sv
module silence_dp
  import silence_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 9600
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  run_cmd_t                   cmd,
  output logic [NUM_CH-1:0]          chanZero,
  output logic                       reached
);
  localparam int CNT_W = $clog2(THRESHOLD + 1);
  localparam logic [CNT_W-1:0] TH_C = CNT_W'(THRESHOLD);

  logic [CNT_W-1:0] runCnt;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_zero
    assign chanZero[ch] = (samples[ch*SAMPLE_W +: SAMPLE_W] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      runCnt <= '0;
    else if (cmd.clr)
      runCnt <= '0;
    else if (cmd.adv && runCnt != TH_C)
      runCnt <= runCnt + 1'b1;
  end

  assign reached = (runCnt == TH_C);

  // R5: run never passes the threshold
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    runCnt <= TH_C);
  // R5: count moves only by restart or single step
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (runCnt != $past(runCnt)) |-> (runCnt == '0 || runCnt == $past(runCnt) + 1'b1));
  // R3: no strobe, count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.clr || cmd.adv) |=> $stable(runCnt));
  // R4: restart empties the run
  a_r4_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (runCnt == '0));
endmodule

// File: rtl/silence_watch.sv
module silence_watch
  import silence_pkg::*;
#(
  parameter int NUM_CH    = 6,
  parameter int SAMPLE_W  = 24,
  parameter int THRESHOLD = 9600
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       frameValid,
  input  logic [NUM_CH*SAMPLE_W-1:0] samples,
  input  logic [NUM_CH-1:0]          partMask,
  input  logic                       staticMode,
  input  logic                       muteReq,
  output logic                       silenceN
);
  logic [NUM_CH-1:0] chanZero;
  logic              reached;
  run_cmd_t          cmd;

  silence_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .chanZero(chanZero),
    .partMask(partMask), .staticMode(staticMode), .cmd(cmd)
  );

  silence_dp #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .THRESHOLD(THRESHOLD)) u_dp (
    .clk(clk), .rstN(rstN), .samples(samples), .cmd(cmd),
    .chanZero(chanZero), .reached(reached)
  );

  assign silenceN = !(muteReq || reached);

  // R4: a restart leaves the flag released unless muted
  a_r4_release: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> (silenceN || muteReq));
  // R9: empty mask in control mode keeps flag high without mute
  a_r9_flag_high: assert property (@(posedge clk) disable iff (!rstN)
    (!staticMode && partMask == '0 && $past(!staticMode && partMask == '0) && !muteReq
      && $past(frameValid)) |-> silenceN);
endmodule

// File: tb/silence_watch_bench.sv
module silence_watch_bench;
  localparam int NCH = 6;
  localparam int SW  = 24;
  localparam int TH  = 5;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameValid = 1'b0;
  logic [NCH*SW-1:0] samples = '0;
  logic [NCH-1:0]    partMask = '1;
  logic              staticMode = 1'b0;
  logic              muteReq = 1'b0;
  logic              silenceN;

  int nChecks = 0;
  int nFails  = 0;
  int model   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  silence_watch #(.NUM_CH(NCH), .SAMPLE_W(SW), .THRESHOLD(TH)) u_silence_watch (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .samples(samples),
    .partMask(partMask), .staticMode(staticMode), .muteReq(muteReq),
    .silenceN(silenceN)
  );

  task automatic check(input string tag);
    logic expv;
    expv = !(muteReq || model == TH);
    nChecks++;
    if (silenceN !== expv) begin
      nFails++;
      $display("FAIL %s: silenceN=%0b expected %0b (run=%0d)", tag, silenceN, expv, model);
    end
  endtask

  // One frame (or idle cycle); inputs applied at negedge, result checked at next negedge
  task automatic frame(input logic v, input logic [NCH*SW-1:0] s, input string tag);
    logic [NCH-1:0] part;
    bit bad;
    frameValid = v;
    samples    = s;
    @(negedge clk);
    part = staticMode ? {NCH{1'b1}} : partMask;
    bad = 1'b0;
    for (int c = 0; c < NCH; c++)
      if (part[c] && s[c*SW +: SW] != '0) bad = 1'b1;
    if (v) begin
      if (bad || part == '0) model = 0;
      else if (model < TH) model = model + 1;
    end
    frameValid = 1'b0;
    check(tag);
  endtask

  function automatic logic [NCH*SW-1:0] oneChan(input int c, input logic [SW-1:0] val);
    logic [NCH*SW-1:0] r;
    r = '0;
    r[c*SW +: SW] = val;
    return r;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");

    // R2 threshold edge and R5 saturation, all channels
    for (int i = 0; i < TH - 1; i++) frame(1'b1, '0, "R2");
    frame(1'b1, '0, "R2");
    for (int i = 0; i < 3; i++) frame(1'b1, '0, "R5");
    // R3: idle cycles with garbage data change nothing
    frame(1'b0, {NCH*SW{1'b1}}, "R3");
    frame(1'b1, oneChan(2, 24'h1), "R4");
    for (int i = 0; i < TH - 1; i++) frame(1'b1, '0, "R5");
    frame(1'b0, {NCH*SW{1'b1}}, "R3");
    frame(1'b1, '0, "R3");

    // R10: single-bit samples
    frame(1'b1, oneChan(0, 24'h000001), "R10");
    for (int i = 0; i < TH; i++) frame(1'b1, '0, "R10");
    frame(1'b1, oneChan(5, 24'h800000), "R10");

    // R6: mute forces flag and leaves count alone
    frame(1'b1, '0, "R6");
    muteReq = 1'b1;
    #1 check("R6");
    for (int i = 0; i < TH - 2; i++) frame(1'b1, '0, "R6");
    muteReq = 1'b0;
    #1 check("R6");
    frame(1'b1, '0, "R6");
    muteReq = 1'b1;
    frame(1'b1, oneChan(1, 24'h5), "R6");
    muteReq = 1'b0;
    #1 check("R6");

    // Sweep every mask in both modes (R7, R8, R9)
    for (int st = 0; st < 2; st++) begin
      for (int m = 0; m < (1 << NCH); m++) begin
        staticMode = st[0];
        partMask   = m[NCH-1:0];
        frame(1'b1, {NCH*SW{1'b1}}, "R4");
        for (int i = 0; i < TH + 1; i++)
          frame(1'b1, '0, (st == 0 && m == 0) ? "R9" : "R2");
        for (int c = 0; c < NCH; c++) begin
          frame(1'b1, oneChan(c, 24'h7), st ? "R8" : ((m == 0) ? "R9" : "R7"));
          for (int i = 0; i < TH; i++) frame(1'b1, '0, "R5");
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule